// File: doc/BRIEF.md
# Crosspoint Routing Program Register

This block holds the routing program for an eight-output, eight-input switch matrix. Each output owns a five-bit slot in a 40-bit load register. The slot holds an enable bit, a must-be-one qualifier bit and a three-bit input select. The register can be reloaded in two ways. A serial stream reloads every slot. An addressed parallel write changes one slot. Bits that leave the far end of the register appear on a serial output, so several devices can be chained on one stream.

A second register stage, the commit stage, drives the matrix controls. It copies the load register whenever the commit pin and the chip-enable pin are both low. While that holds it is transparent, so each change to the load register reaches the matrix on the next system clock. Several parallel writes can therefore be staged with commit held high and then applied together.

All programming pins are asynchronous to the system clock. Each passes through two flip-flops before use. Programming-clock falling edges are detected from the synchronised samples.

Top module: `xpt_cfg_latch`

## Requirements
- R1: In serial mode (`par_mode_i`=0, `chip_en_n_i`=0), each programming-clock falling edge shifts `ser_in_i` into the load register. The first bit of a 40-bit frame lands in the slot of output 7 and the last in the slot of output 0. Within a slot the bits arrive as enable, qualifier, then select bit 2, bit 1, bit 0.
- R2: While `commit_n_i` and `chip_en_n_i` are both low, the route outputs follow the load register. While `commit_n_i` is high they hold their value.
- R3: If `commit_n_i` is low during shifting, every intermediate register state appears on the route outputs.
- R4: In parallel mode with `commit_n_i` high, a falling edge writes `slot_data_i` into the slot chosen by `slot_addr_i`. Bit 3 of the data is the enable and bits 2..0 are the select. The qualifier bit is forced to 1. Other slots keep their values.
- R5: Several parallel writes staged with `commit_n_i` high leave the outputs unchanged. They take effect together when `commit_n_i` goes low.
- R6: A falling edge in parallel mode while `commit_n_i` is low does not change the load register or the outputs.
- R7: Output k is enabled only when both its enable bit and its qualifier bit are 1. A disabled output drives a select of 0.
- R8: An active-low reset drives every `route_en_o` bit to 0 and leaves the load register intact. A later commit restores the stored program.
- R9: `ser_out_o` presents load-register bit 39, which is the oldest bit of the frame in the register.
- R10: While `chip_en_n_i` is high, programming-clock edges are ignored and the route outputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_n_i | input | 1 | Active-low reset; disables all outputs |
| prog_clk_i | input | 1 | Programming clock pin; falling edge acts |
| chip_en_n_i | input | 1 | Active-low chip enable |
| commit_n_i | input | 1 | Active-low commit; the commit stage is transparent while it and chip enable are low |
| par_mode_i | input | 1 | 0 = serial load, 1 = parallel addressed write |
| ser_in_i | input | 1 | Serial data in |
| slot_addr_i | input | 3 | Output slot addressed by a parallel write |
| slot_data_i | input | 4 | Parallel data: bit 3 enable, bits 2..0 select |
| ser_out_o | output | 1 | Serial data out for chaining |
| route_en_o | output | 8 | Per-output enable |
| route_sel_o | output | 24 | Per-output input select, 3 bits per output, output k at bits 3k+2..3k |

## Verification
The assertions take for granted that every programming pin stays steady for at least three system clocks around each programming-clock edge. A data pin that changes in the same synchroniser window as the clock would be sampled with a skew of one cycle. The stimulus moves one pin at a time and then waits four system clocks before the next change. This keeps address, data and serial input settled before each falling edge, and the commit pulse well clear of any edge.

// File: rtl/xpt_cfg_latch.sv
module xpt_cfg_latch #(
  parameter int N_OUT = 8,
  parameter int SEL_W = 3
) (
  input  logic                      clk_i,
  input  logic                      rst_n_i,
  input  logic                      prog_clk_i,
  input  logic                      chip_en_n_i,
  input  logic                      commit_n_i,
  input  logic                      par_mode_i,
  input  logic                      ser_in_i,
  input  logic [$clog2(N_OUT)-1:0]  slot_addr_i,
  input  logic [SEL_W:0]            slot_data_i,
  output logic                      ser_out_o,
  output logic [N_OUT-1:0]          route_en_o,
  output logic [N_OUT*SEL_W-1:0]    route_sel_o
);
  localparam int SLOT_W = SEL_W + 2;
  localparam int REG_W  = N_OUT * SLOT_W;
  localparam int ADDR_W = $clog2(N_OUT);
  localparam int PIN_W  = 5 + ADDR_W + SEL_W + 1;
  localparam logic [PIN_W-1:0] PIN_IDLE = {1'b1, 1'b1, 1'b1, {(PIN_W-3){1'b0}}};

  logic [PIN_W-1:0] pin_q1, pin_q2;
  logic             pclk_q3;
  logic [REG_W-1:0] load_q, hold_q;

  always_ff @(posedge clk_i) begin
    if (!rst_n_i) begin
      pin_q1  <= PIN_IDLE;
      pin_q2  <= PIN_IDLE;
      pclk_q3 <= 1'b1;
    end else begin
      pin_q1  <= {prog_clk_i, chip_en_n_i, commit_n_i, par_mode_i, ser_in_i, slot_addr_i, slot_data_i};
      pin_q2  <= pin_q1;
      pclk_q3 <= pin_q2[PIN_W-1];
    end
  end

  logic              pclk_s, cen_n_s, cmt_n_s, par_s, sdi_s;
  logic [ADDR_W-1:0] addr_s;
  logic [SEL_W:0]    data_s;
  assign {pclk_s, cen_n_s, cmt_n_s, par_s, sdi_s, addr_s, data_s} = pin_q2;

  wire fall   = pclk_q3 & ~pclk_s & ~cen_n_s;
  wire sh_ser = fall & ~par_s;
  wire wr_par = fall & par_s & cmt_n_s;
  wire xfer   = ~cen_n_s & ~cmt_n_s;

  always_ff @(posedge clk_i) begin
    if (sh_ser)
      load_q <= {load_q[REG_W-2:0], sdi_s};
    else if (wr_par)
      for (int k = 0; k < N_OUT; k++)
        if (addr_s == ADDR_W'(k))
          load_q[k*SLOT_W +: SLOT_W] <= {data_s[SEL_W], 1'b1, data_s[SEL_W-1:0]};
  end

  always_ff @(posedge clk_i) begin
    if (!rst_n_i) begin
      for (int k = 0; k < N_OUT; k++)
        hold_q[k*SLOT_W + SLOT_W-1] <= 1'b0;
    end else if (xfer) begin
      hold_q <= load_q;
    end
  end

  assign ser_out_o = load_q[REG_W-1];

  for (genvar k = 0; k < N_OUT; k++) begin : g_out
    wire on = hold_q[k*SLOT_W + SLOT_W-1] & hold_q[k*SLOT_W + SLOT_W-2];
    assign route_en_o[k] = on;
    assign route_sel_o[k*SEL_W +: SEL_W] = on ? hold_q[k*SLOT_W +: SEL_W] : '0;
  end

  assert_reset_disables_R8: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $rose(rst_n_i) |-> route_en_o == '0);

  assert_hold_without_commit_R2: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    cmt_n_s |=> $stable(route_en_o) && $stable(route_sel_o));

  assert_deselect_holds_R10: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    cen_n_s |=> $stable(route_en_o) && $stable(route_sel_o) && $stable(ser_out_o));

  assert_serial_out_advance_R9: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    sh_ser |=> ser_out_o == $past(load_q[REG_W-2]));

  assert_par_ignored_on_commit_R6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (par_s && !cmt_n_s) |=> $stable(load_q));

  assert_par_qualifier_set_R4: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    wr_par |=> load_q[int'($past(addr_s))*SLOT_W + SLOT_W-2]);
endmodule

// File: tb/xpt_cfg_latch_tb_top.sv
module xpt_cfg_latch_tb_top;
  logic clk = 0, rst_n = 0;
  logic prog_clk = 1, chip_en_n = 1, commit_n = 1, par_mode = 0, ser_in = 0;
  logic [2:0] slot_addr = 0;
  logic [3:0] slot_data = 0;
  logic ser_out;
  logic [7:0] route_en;
  logic [23:0] route_sel;
  int vectors = 0, miscompares = 0;
  logic [39:0] exp_sr = '0, exp_lat = '0;
  logic rst_view = 1;

  always #2 clk = ~clk;

  xpt_cfg_latch dut_i (
    .clk_i(clk), .rst_n_i(rst_n), .prog_clk_i(prog_clk), .chip_en_n_i(chip_en_n),
    .commit_n_i(commit_n), .par_mode_i(par_mode), .ser_in_i(ser_in),
    .slot_addr_i(slot_addr), .slot_data_i(slot_data), .ser_out_o(ser_out),
    .route_en_o(route_en), .route_sel_o(route_sel));

  function automatic logic [7:0] en_of(logic [39:0] r);
    for (int k = 0; k < 8; k++) en_of[k] = r[5*k+4] & r[5*k+3];
  endfunction

  function automatic logic [23:0] sel_of(logic [39:0] r);
    for (int k = 0; k < 8; k++) sel_of[3*k +: 3] = (r[5*k+4] & r[5*k+3]) ? r[5*k +: 3] : 3'd0;
  endfunction

  task automatic step(); repeat (4) @(posedge clk); endtask

  task automatic check_out(string req);
    logic [7:0] ee;
    logic [23:0] es;
    @(negedge clk);
    ee = rst_view ? 8'h00 : en_of(exp_lat);
    es = rst_view ? route_sel : sel_of(exp_lat);
    vectors++;
    if (route_en !== ee || route_sel !== es) begin
      miscompares++;
      $display("FAIL %s: en=%h sel=%h expected en=%h sel=%h", req, route_en, route_sel, ee, es);
    end
  endtask

  task automatic fall(); prog_clk = 0; step(); prog_clk = 1; step(); endtask

  task automatic commit(); commit_n = 0; step(); exp_lat = exp_sr; rst_view = 0; commit_n = 1; step(); endtask

  task automatic ser_load(logic [39:0] v, bit watch, bit live);
    for (int i = 39; i >= 0; i--) begin
      if (watch) begin
        @(negedge clk);
        vectors++;
        if (ser_out !== exp_sr[39]) begin
          miscompares++;
          $display("FAIL R9: ser_out=%b expected %b", ser_out, exp_sr[39]);
        end
      end
      ser_in = v[i]; step(); fall();
      exp_sr = {exp_sr[38:0], v[i]};
      if (live) begin exp_lat = exp_sr; check_out("R3 live shift"); end
    end
  endtask

  task automatic par_write(logic [2:0] a, logic [3:0] d, bit apply);
    slot_addr = a; slot_data = d; step(); fall();
    if (apply) exp_sr[5*a +: 5] = {d[3], 1'b1, d[2:0]};
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: run hung, expected completion");
    finish_run();
  end

  initial begin
    repeat (5) @(posedge clk);
    rst_n = 1; step();
    check_out("R8 reset state");
    chip_en_n = 0; step();
    for (int p = 0; p < 8; p++) begin
      logic [39:0] v;
      for (int k = 0; k < 8; k++)
        v[5*k +: 5] = {((k + p) % 3 != 0), ((k + 2*p) % 5 != 0), 3'((3*k + p) & 7)};
      ser_load(v, p == 1, 0);
      check_out("R2 hold while commit high");
      commit();
      check_out("R1 serial frame order / R7 qualifier");
    end
    commit_n = 0; step();
    ser_load(40'h5A_C3_96_E1_7F, 0, 1);
    commit_n = 1; step();
    par_mode = 1; step();
    for (int a = 0; a < 8; a++)
      for (int d = 0; d < 16; d++) begin
        par_write(3'(a), 4'(d), 1);
        commit();
        check_out("R4 parallel slot write");
      end
    par_write(3'd1, 4'hA, 1); check_out("R5 staged hold");
    par_write(3'd4, 4'h3, 1); check_out("R5 staged hold");
    par_write(3'd6, 4'hF, 1); check_out("R5 staged hold");
    commit(); check_out("R5 applied together");
    commit_n = 0; step();
    exp_lat = exp_sr;
    par_write(3'd6, 4'h8, 0); check_out("R6 write ignored");
    par_write(3'd2, 4'hD, 0); check_out("R6 write ignored");
    commit_n = 1; step(); commit(); check_out("R6 register unchanged");
    commit_n = 0; step();
    chip_en_n = 1; step();
    par_write(3'd0, 4'h9, 0); check_out("R10 parallel edge ignored");
    par_mode = 0; step();
    ser_in = 1; step(); fall(); ser_in = 0; step(); fall(); fall();
    check_out("R10 serial edges ignored");
    commit_n = 1; step(); chip_en_n = 0; step();
    commit(); check_out("R10 register unchanged");
    rst_n = 0; rst_view = 1; step(); rst_n = 1; step();
    check_out("R8 reset disables outputs");
    chip_en_n = 0; step();
    commit(); check_out("R8 program kept through reset");
    ser_load(40'hFF_FF_FF_FF_FF, 0, 0);
    commit(); check_out("R7 all enabled select 7");
    ser_load(40'h7B_DE_F7_BD_EF, 1, 0);
    commit(); check_out("R7 all disabled select 0");
    finish_run();
  end
endmodule